// File: doc/BRIEF.md
# Multi-Mailbox Ring Buffer Controller

This block keeps four ring-buffer mailboxes that live in external memory. A producing engine posts indications, one word each, into a chosen mailbox. The block turns each accepted indication into a single memory write at that mailbox's write pointer. It then advances the pointer, wrapping back to the region's first address when the pointer would reach the exclusive upper limit. A host consumes entries and reports its progress by writing a tail address. When the advanced write pointer lands on that tail, the mailbox is full.

Per-mailbox status flags record "message posted" and "mailbox full". The host clears them by writing ones. A maskable interrupt is formed from the flags. While any full flag is set, the block stops taking indications and raises a halt output. Host configuration writes and flag clears keep working in that state, so the host can free space, clear the flag and let the engine resume.

Top module: `mbx_ring_ctrl`

## Requirements
- R1: After reset, status_mm, status_mf, irq, halt and mem_we are all 0, and no mask bit is set. Mailbox i starts with start = i*16, an exclusive bottom of start+16, and tail and write pointer both equal to start.
- R2: An indication is accepted when ind_valid is 1 and halt is 0. On the next cycle mem_we is 1 for exactly one cycle, mem_addr holds the mailbox's write pointer before the advance, and mem_wdata holds ind_data.
- R3: Each accepted indication advances that mailbox's write pointer by one. When pointer+1 equals the bottom address, the pointer is loaded with the start address instead.
- R4: Each accepted indication sets status_mm[m] of its mailbox m in the cycle that mem_we rises.
- R5: If the advanced write pointer equals the tail address, status_mf[m] is set in that same cycle.
- R6: halt is 1 whenever any status_mf bit is set. An indication presented while halt is 1 is ignored: no memory write occurs and no pointer moves.
- R7: With clr_we at 1, each 1 in clr_mm or clr_mf clears that status bit. If a set and a clear hit the same bit in the same cycle, the set wins.
- R8: irq is 1 when some status bit is set and its mask is clear. A host write with cfg_field = 3 loads the mailbox's masks: cfg_data[0] masks MM and cfg_data[1] masks MF.
- R9: Host writes use cfg_field 0 for start, 1 for bottom and 2 for tail. Writing start also loads the write pointer with the new start, and this takes priority over an advance in the same cycle.
- R10: If a tail write and an accepted indication target the same mailbox in the same cycle, the full comparison uses the new tail value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Host configuration write strobe |
| cfg_mbox | input | 2 | Mailbox addressed by the host write |
| cfg_field | input | 2 | 0 start, 1 bottom, 2 tail, 3 masks |
| cfg_data | input | 12 | Address value, or masks in bits 1:0 |
| clr_we | input | 1 | Status clear strobe |
| clr_mm | input | 4 | Write-one-to-clear for the message flags |
| clr_mf | input | 4 | Write-one-to-clear for the full flags |
| ind_valid | input | 1 | Indication request |
| ind_mbox | input | 2 | Target mailbox of the indication |
| ind_data | input | 32 | Indication word |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| status_mm | output | 4 | Message-posted flags |
| status_mf | output | 4 | Mailbox-full flags |
| irq | output | 1 | Interrupt request |
| halt | output | 1 | High while any mailbox is full |

## Verification
A wrong write pointer appears on mem_addr at the next write to that mailbox, one cycle after acceptance. A wrap error appears at the write that crosses the bottom address. A wrong full decision either raises halt one cycle after the faulty write, or lets halt stay low and a later write overwrite the unread entry at the tail. Leaked or lost status bits appear directly on status_mm, status_mf and irq in the cycle after the event. An indication wrongly taken while halted appears as a stray mem_we pulse, and also as a skipped address on the next write.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int CFG_FIELD_W = 2;

  typedef enum logic [CFG_FIELD_W-1:0] {
    F_START  = 2'd0,
    F_BOTTOM = 2'd1,
    F_TAIL   = 2'd2,
    F_MASK   = 2'd3
  } cfg_field_e;
endpackage

// File: rtl/mbx_ptr_slice.sv
module mbx_ptr_slice
  import mbx_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int RST_START  = 0,
  parameter int RST_BOTTOM = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_hit,
  input  logic [CFG_FIELD_W-1:0] cfg_field,
  input  logic [ADDR_W-1:0]      cfg_data,
  input  logic                   adv,
  output logic [ADDR_W-1:0]      wptr,
  output logic                   full_hit,
  output logic                   wrap_hit
);
  logic [ADDR_W-1:0] start_q, bottom_q, tail_q, tail_eff, nxt;

  function automatic logic [ADDR_W-1:0] next_ptr(
    input logic [ADDR_W-1:0] wp, st, bt);
    logic [ADDR_W-1:0] inc;
    inc = wp + ADDR_W'(1);
    return (inc == bt) ? st : inc;
  endfunction

  function automatic logic lands_on(
    input logic [ADDR_W-1:0] nx, tl);
    return nx == tl;
  endfunction

  // tail written this cycle is compared first (R10)
  assign tail_eff = (cfg_hit && cfg_field == F_TAIL) ? cfg_data : tail_q;
  assign nxt      = next_ptr(wptr, start_q, bottom_q);
  assign full_hit = adv && lands_on(nxt, tail_eff);
  assign wrap_hit = adv && (wptr + ADDR_W'(1) == bottom_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q  <= ADDR_W'(RST_START);
      bottom_q <= ADDR_W'(RST_BOTTOM);
      tail_q   <= ADDR_W'(RST_START);
      wptr     <= ADDR_W'(RST_START);
    end else begin
      if (cfg_hit && cfg_field == F_START)  start_q  <= cfg_data;
      if (cfg_hit && cfg_field == F_BOTTOM) bottom_q <= cfg_data;
      if (cfg_hit && cfg_field == F_TAIL)   tail_q   <= cfg_data;
      if (cfg_hit && cfg_field == F_START)  wptr     <= cfg_data;
      else if (adv)                         wptr     <= nxt;
    end
  end
endmodule

// File: rtl/mbx_status.sv
module mbx_status #(
  parameter int N_MBOX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_MBOX-1:0] set_mm,
  input  logic [N_MBOX-1:0] set_mf,
  input  logic              clr_we,
  input  logic [N_MBOX-1:0] clr_mm,
  input  logic [N_MBOX-1:0] clr_mf,
  input  logic [N_MBOX-1:0] mask_we,
  input  logic [1:0]        mask_data,
  output logic [N_MBOX-1:0] status_mm,
  output logic [N_MBOX-1:0] status_mf,
  output logic              irq,
  output logic              halt
);
  logic [N_MBOX-1:0] mask_mm, mask_mf, clr_mm_eff, clr_mf_eff;

  function automatic logic [N_MBOX-1:0] w1c_update(
    input logic [N_MBOX-1:0] cur, set, clr);
    return set | (cur & ~clr);
  endfunction

  assign clr_mm_eff = clr_we ? clr_mm : '0;
  assign clr_mf_eff = clr_we ? clr_mf : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_mm <= '0;
      status_mf <= '0;
    end else begin
      status_mm <= w1c_update(status_mm, set_mm, clr_mm_eff);
      status_mf <= w1c_update(status_mf, set_mf, clr_mf_eff);
    end
  end

  for (genvar i = 0; i < N_MBOX; i++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_mm[i] <= 1'b0;
        mask_mf[i] <= 1'b0;
      end else if (mask_we[i]) begin
        mask_mm[i] <= mask_data[0];
        mask_mf[i] <= mask_data[1];
      end
    end
  end

  assign irq  = |((status_mm & ~mask_mm) | (status_mf & ~mask_mf));
  assign halt = |status_mf;
endmodule

// File: rtl/mbx_mem_port.sv
module mbx_mem_port #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= fire;
      if (fire) begin
        mem_addr  <= addr;
        mem_wdata <= data;
      end
    end
  end
endmodule

// File: rtl/mbx_ring_ctrl.sv
module mbx_ring_ctrl
  import mbx_pkg::*;
#(
  parameter int N_MBOX    = 4,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int DEF_DEPTH = 16,
  localparam int IDX_W    = (N_MBOX > 1) ? $clog2(N_MBOX) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [IDX_W-1:0]       cfg_mbox,
  input  logic [CFG_FIELD_W-1:0] cfg_field,
  input  logic [ADDR_W-1:0]      cfg_data,
  input  logic                   clr_we,
  input  logic [N_MBOX-1:0]      clr_mm,
  input  logic [N_MBOX-1:0]      clr_mf,
  input  logic                   ind_valid,
  input  logic [IDX_W-1:0]       ind_mbox,
  input  logic [DATA_W-1:0]      ind_data,
  output logic                   mem_we,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [DATA_W-1:0]      mem_wdata,
  output logic [N_MBOX-1:0]      status_mm,
  output logic [N_MBOX-1:0]      status_mf,
  output logic                   irq,
  output logic                   halt
);
  // named internal events, observed by the checker
  logic                ind_fire;
  logic [N_MBOX-1:0]   fire_onehot;
  logic [N_MBOX-1:0]   cfg_hit;
  logic [N_MBOX-1:0]   mask_we;
  logic [N_MBOX-1:0]   full_hit;
  logic [N_MBOX-1:0]   wrap_hit;
  logic [ADDR_W-1:0]   wptr [N_MBOX];
  logic [ADDR_W-1:0]   sel_wptr;

  assign ind_fire = ind_valid && !halt;

  for (genvar i = 0; i < N_MBOX; i++) begin : g_mbox
    assign fire_onehot[i] = ind_fire && (ind_mbox == IDX_W'(i));
    assign cfg_hit[i]     = cfg_we && (cfg_mbox == IDX_W'(i));
    assign mask_we[i]     = cfg_hit[i] && (cfg_field == F_MASK);

    mbx_ptr_slice #(
      .ADDR_W    (ADDR_W),
      .RST_START (i * DEF_DEPTH),
      .RST_BOTTOM((i + 1) * DEF_DEPTH)
    ) i_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_hit  (cfg_hit[i]),
      .cfg_field(cfg_field),
      .cfg_data (cfg_data),
      .adv      (fire_onehot[i]),
      .wptr     (wptr[i]),
      .full_hit (full_hit[i]),
      .wrap_hit (wrap_hit[i])
    );
  end

  always_comb begin
    sel_wptr = wptr[0];
    for (int i = 1; i < N_MBOX; i++)
      if (ind_mbox == IDX_W'(i)) sel_wptr = wptr[i];
  end

  mbx_status #(.N_MBOX(N_MBOX)) i_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_mm   (fire_onehot),
    .set_mf   (full_hit),
    .clr_we   (clr_we),
    .clr_mm   (clr_mm),
    .clr_mf   (clr_mf),
    .mask_we  (mask_we),
    .mask_data(cfg_data[1:0]),
    .status_mm(status_mm),
    .status_mf(status_mf),
    .irq      (irq),
    .halt     (halt)
  );

  mbx_mem_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (ind_fire),
    .addr     (sel_wptr),
    .data     (ind_data),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata)
  );
endmodule

// File: rtl/mbx_ring_ctrl_chk.sv
module mbx_ring_ctrl_chk #(
  parameter int N_MBOX = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ind_fire,
  input logic [N_MBOX-1:0] fire_onehot,
  input logic [N_MBOX-1:0] full_hit,
  input logic [N_MBOX-1:0] wrap_hit,
  input logic              mem_we,
  input logic              halt,
  input logic              irq,
  input logic [N_MBOX-1:0] status_mm,
  input logic [N_MBOX-1:0] status_mf
);
  // R2: one memory write follows each accepted indication
  a_r2_write_follows_fire: assert property (@(posedge clk) disable iff (!rst_n)
    ind_fire |=> mem_we);
  a_r2_no_spurious_write: assert property (@(posedge clk) disable iff (!rst_n)
    !ind_fire |=> !mem_we);
  // R4: the targeted message flag is set after acceptance
  a_r4_mm_set: assert property (@(posedge clk) disable iff (!rst_n)
    ind_fire |=> ((status_mm & $past(fire_onehot)) == $past(fire_onehot)));
  // R5: a full hit sets the full flag
  a_r5_mf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|full_hit) |=> ((status_mf & $past(full_hit)) == $past(full_hit)));
  // R6: nothing is written while halted, halt only rises after a write
  a_r6_halt_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !mem_we);
  a_r6_halt_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt) |-> $past(ind_fire));
  // R3: at most one mailbox wraps per cycle
  a_r3_single_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wrap_hit));
  // R8: no interrupt without a status flag
  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (status_mm == '0 && status_mf == '0) |-> !irq);
endmodule

bind mbx_ring_ctrl mbx_ring_ctrl_chk #(.N_MBOX(N_MBOX)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ind_fire   (ind_fire),
  .fire_onehot(fire_onehot),
  .full_hit   (full_hit),
  .wrap_hit   (wrap_hit),
  .mem_we     (mem_we),
  .halt       (halt),
  .irq        (irq),
  .status_mm  (status_mm),
  .status_mf  (status_mf)
);

// File: tb/test_mbx_ring_ctrl.sv
module test_mbx_ring_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_mbox = '0;
  logic [1:0]  cfg_field = '0;
  logic [11:0] cfg_data = '0;
  logic        clr_we = 1'b0;
  logic [3:0]  clr_mm = '0, clr_mf = '0;
  logic        ind_valid = 1'b0;
  logic [1:0]  ind_mbox = '0;
  logic [31:0] ind_data = '0;
  logic        mem_we, irq, halt;
  logic [11:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0]  status_mm, status_mf;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  mbx_ring_ctrl i_mbx_ring_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mbox(cfg_mbox),
    .cfg_field(cfg_field), .cfg_data(cfg_data), .clr_we(clr_we),
    .clr_mm(clr_mm), .clr_mf(clr_mf), .ind_valid(ind_valid),
    .ind_mbox(ind_mbox), .ind_data(ind_data), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .status_mm(status_mm),
    .status_mf(status_mf), .irq(irq), .halt(halt)
  );

  localparam int NV = 8;
  localparam logic [1:0]  V_MB   [NV] = '{2'd0, 2'd1, 2'd0, 2'd3, 2'd2, 2'd1, 2'd0, 2'd2};
  localparam logic [11:0] V_ADDR [NV] = '{12'h000, 12'h010, 12'h001, 12'h030,
                                          12'h020, 12'h011, 12'h002, 12'h021};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] m, input logic [1:0] f, input logic [11:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mbox = m; cfg_field = f; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clr(input logic [3:0] mm, input logic [3:0] mf);
    @(negedge clk);
    clr_we = 1'b1; clr_mm = mm; clr_mf = mf;
    @(negedge clk);
    clr_we = 1'b0; clr_mm = '0; clr_mf = '0;
  endtask

  // drive one indication; returns at the negedge after the accepting edge
  task automatic ind(input logic [1:0] m, input logic [31:0] d);
    @(negedge clk);
    ind_valid = 1'b1; ind_mbox = m; ind_data = d;
    @(negedge clk);
    ind_valid = 1'b0;
  endtask

  task automatic ind_at(input string req, input logic [1:0] m, input logic [11:0] a);
    ind(m, {20'hC0DE0, a});
    chk(req, {31'b0, mem_we}, 32'd1);
    chk(req, {20'b0, mem_addr}, {20'b0, a});
    chk(req, mem_wdata, {20'hC0DE0, a});
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mm", {28'b0, status_mm}, 0);
    chk("R1 mf", {28'b0, status_mf}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 halt", {31'b0, halt}, 0);
    chk("R1 mem_we", {31'b0, mem_we}, 0);

    // vector table: R2 R3 R4 with reset regions
    for (int v = 0; v < NV; v++) begin
      ind(V_MB[v], 32'hA000_0000 + v);
      chk("R2 we", {31'b0, mem_we}, 1);
      chk("R3 addr", {20'b0, mem_addr}, {20'b0, V_ADDR[v]});
      chk("R2 data", mem_wdata, 32'hA000_0000 + v);
      chk("R4 mm", {31'b0, status_mm[V_MB[v]]}, 1);
      @(negedge clk);
      chk("R2 single", {31'b0, mem_we}, 0);
    end
    chk("R8 irq on", {31'b0, irq}, 1);

    // R7 write-one-to-clear
    clr(4'hF, 4'h0);
    chk("R7 mm cleared", {28'b0, status_mm}, 0);
    chk("R8 irq off", {31'b0, irq}, 0);

    // R8 masking
    cfg(2'd0, 2'd3, 12'h001);
    ind_at("R8 masked write", 2'd0, 12'h003);
    chk("R8 mm still set", {31'b0, status_mm[0]}, 1);
    chk("R8 masked irq", {31'b0, irq}, 0);
    cfg(2'd0, 2'd3, 12'h000);
    chk("R8 unmasked irq", {31'b0, irq}, 1);
    clr(4'h1, 4'h0);

    // R9 start load resets write pointer
    cfg(2'd1, 2'd1, 12'h058);
    cfg(2'd1, 2'd0, 12'h050);
    ind_at("R9 start load", 2'd1, 12'h050);
    ind_at("R9 after start", 2'd1, 12'h051);

    // R3 wrap and R5 full on mailbox 2
    cfg(2'd2, 2'd0, 12'h100);
    cfg(2'd2, 2'd1, 12'h104);
    cfg(2'd2, 2'd2, 12'h100);
    ind_at("R3 ring", 2'd2, 12'h100);
    ind_at("R3 ring", 2'd2, 12'h101);
    ind_at("R3 ring", 2'd2, 12'h102);
    chk("R5 not yet full", {28'b0, status_mf}, 0);
    ind_at("R3 last slot", 2'd2, 12'h103);
    chk("R5 full at wrap", {28'b0, status_mf}, 32'h4);
    chk("R6 halt", {31'b0, halt}, 1);
    chk("R8 irq full", {31'b0, irq}, 1);

    // R6 ignored while halted
    ind(2'd0, 32'hDEAD_BEEF);
    chk("R6 ignored", {31'b0, mem_we}, 0);
    @(negedge clk);
    chk("R6 still ignored", {31'b0, mem_we}, 0);

    // release, then pointers unchanged
    cfg(2'd2, 2'd2, 12'h102);
    clr(4'h0, 4'h4);
    chk("R6 released", {31'b0, halt}, 0);
    ind_at("R6 no advance while halted", 2'd0, 12'h004);
    ind_at("R3 wrapped to start", 2'd2, 12'h100);
    ind_at("R5 reach tail", 2'd2, 12'h101);
    chk("R5 full again", {28'b0, status_mf}, 32'h4);
    clr(4'hF, 4'hF);
    chk("R7 mf cleared", {28'b0, status_mf}, 0);

    // R10 same-cycle tail write, R7 set beats clear
    @(negedge clk);
    cfg_we = 1'b1; cfg_mbox = 2'd3; cfg_field = 2'd2; cfg_data = 12'h032;
    ind_valid = 1'b1; ind_mbox = 2'd3; ind_data = 32'h0000_0333;
    clr_we = 1'b1; clr_mm = 4'h8;
    @(negedge clk);
    cfg_we = 1'b0; ind_valid = 1'b0; clr_we = 1'b0; clr_mm = '0;
    chk("R10 addr", {20'b0, mem_addr}, 32'h031);
    chk("R10 full on new tail", {28'b0, status_mf}, 32'h8);
    chk("R7 set wins", {31'b0, status_mm[3]}, 1);
    chk("R10 halt", {31'b0, halt}, 1);

    summary();
  end
endmodule